// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block sits between one processor and a shared snooping bus. It keeps a small direct-mapped cache, one data word per line, and tags every line with a coherence state: Invalid, Shared or Modified. Processor reads and writes that the current state allows finish locally in the cycle they are presented. All other accesses start a bus transaction. The controller raises a request, waits for the arbiter's grant, drives the command and address, and finishes when the bus signals completion.

A separate snoop port watches transactions issued by other controllers. When another cache reads or claims a line this cache holds dirty, the controller drives the line data out (a flush) in the same cycle and adjusts the state. A clean copy is dropped when another cache claims the line exclusively. Memory and the arbiter belong to the surroundings.

The address splits into an index (the low `IDX_W` bits) and a tag (the remaining upper bits). Internally the states are encoded I=00, S=01, M=11.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_ready`, `bus_req` and `snp_flush` are low, so the first access to any address needs a bus transaction.
- R2: With the controller idle and no snoop present, three accesses complete with `cpu_ready` high in the same cycle they are presented, and no bus transaction is issued. These are a read of a Shared or Modified line and a write to a Modified line. A read returns the line's current word on `cpu_rdata`.
- R3: A write to a Shared line first issues a read-exclusive (`bus_cmd` = 2) for that address. Once that completes, the line is Modified and the write finishes locally.
- R4: A read that misses (tag differs or line Invalid) issues a bus read (`bus_cmd` = 1). The word on `bus_rdata` is installed as Shared and is returned to the processor.
- R5: A write that misses issues a read-exclusive. The fetched block is installed as Modified, and the write then completes locally with no further bus traffic.
- R6: A snooped bus read (`snp_cmd` = 1) whose tag matches a Modified line causes two things. In that cycle `snp_flush` is high and `snp_data` carries the line word. Afterwards the line is Shared.
- R7: A snooped read-exclusive (`snp_cmd` = 2) that matches a line invalidates it. A Modified line also flushes its data in that cycle; a Shared line does not flush.
- R8: A snooped write-back (`snp_cmd` = 3), a snoop with a non-matching tag, or a snoop to an Invalid line produces no flush and leaves the line state unchanged.
- R9: An access that misses on a Modified line first writes the old line back (`bus_cmd` = 3, old tag and index, old word on `bus_wdata`). That write-back completes before the read or read-exclusive for the new block is issued.
- R10: A miss that replaces a Shared line issues only the fetch for the new block, with no write-back.
- R11: `bus_req` stays high from the cycle after a miss until the cycle in which `bus_gnt` and `bus_done` are both high. `bus_cmd` is 0 unless `bus_gnt` is high. `cpu_ready` is low while `bus_req` is high.
- R12: In a cycle where `snp_valid` is high, the processor request is not completed. It is evaluated again in the next cycle against the state the snoop left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction pending |
| bus_gnt | input | 1 | Arbiter grant |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address, valid while granted |
| bus_wdata | output | DATA_W | Write-back data |
| bus_done | input | 1 | Transaction completes this cycle (with grant) |
| bus_rdata | input | DATA_W | Fetched word, valid with `bus_done` |
| snp_valid | input | 1 | Another controller's transaction is visible |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies the dirty word |
| snp_data | output | DATA_W | Flushed word |

## Verification
The bench first upgrades a Shared line on a write. A controller that treated Shared as writable would finish the write with no read-exclusive, leaving stale copies in other caches. It evicts a dirty line and checks that the write-back carries the old tag and word and comes before the fetch. An ordering mistake would lose data or put the wrong address on the bus. It then evicts a clean line, where an extra write-back would show as unexpected bus traffic. Finally it presents a snoop in the same cycle as a processor access to the same line. A design without snoop priority would complete the access against stale state: it would return data from a line that was just taken away, or skip the read-exclusive after losing ownership.

// File: rtl/msi_pkg.sv
// Package: shared encodings for the MSI cache controller.
// Assumes: line states and bus commands fit in two bits each.
package msi_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_MOD = 2'b11
    } line_st_e;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_RDX  = 2'd2,
        BUS_WB   = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WB   = 2'd1,
        PH_FILL = 2'd2
    } phase_e;
endpackage

// File: rtl/msi_line_store.sv
// Module: tag, state and data storage for a direct-mapped set of lines.
// Two combinational read ports (processor side, snoop side) and four
// write sources. When several hit the same line in one cycle, the later
// one in this order wins: snoop state update, processor data write,
// invalidate after write-back, fill.
// Assumes: the write sources are qualified by the caller.
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_dat,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_dat,
    input  logic              snp_we,
    input  logic [IDX_W-1:0]  snp_idx,
    input  line_st_e          snp_st,
    input  logic              cpu_we,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [DATA_W-1:0] cpu_dat,
    input  logic              inv_we,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_dat,
    input  line_st_e          fill_st,
    output logic [2*(1<<IDX_W)-1:0] st_vec
);
    localparam int LINES = 1 << IDX_W;

    line_st_e          st_arr  [LINES];
    logic [TAG_W-1:0]  tag_arr [LINES];
    logic [DATA_W-1:0] dat_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_st_e          st_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] dat_q;

        // Per-line register update with fixed write-source priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= LS_INV;
                tag_q <= '0;
                dat_q <= '0;
            end else begin
                if (snp_we && snp_idx == IDX_W'(g))
                    st_q <= snp_st;
                if (cpu_we && cpu_idx == IDX_W'(g))
                    dat_q <= cpu_dat;
                if (inv_we && inv_idx == IDX_W'(g))
                    st_q <= LS_INV;
                if (fill_we && fill_idx == IDX_W'(g)) begin
                    st_q  <= fill_st;
                    tag_q <= fill_tag;
                    dat_q <= fill_dat;
                end
            end
        end

        assign st_arr[g]  = st_q;
        assign tag_arr[g] = tag_q;
        assign dat_arr[g] = dat_q;
        assign st_vec[2*g +: 2] = st_q;
    end

    assign a_st  = st_arr[a_idx];
    assign a_tag = tag_arr[a_idx];
    assign a_dat = dat_arr[a_idx];
    assign b_st  = st_arr[b_idx];
    assign b_tag = tag_arr[b_idx];
    assign b_dat = dat_arr[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
// Module: decodes one snooped bus command against the addressed line.
// Produces the flush response in the same cycle and the state update
// that the line store applies at the next edge.
// Assumes: the caller presents the line selected by the snoop index.
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  bus_op_e           snp_op,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_e          l_st,
    input  logic [TAG_W-1:0]  l_tag,
    input  logic [DATA_W-1:0] l_dat,
    output logic              flush,
    output logic [DATA_W-1:0] flush_dat,
    output logic              upd_we,
    output line_st_e          upd_st
);
    logic hit;

    // Snoop response and next-state decode.
    always_comb begin
        hit       = snp_valid && (l_st != LS_INV) && (l_tag == snp_tag);
        flush     = hit && (l_st == LS_MOD) && (snp_op == BUS_RD || snp_op == BUS_RDX);
        flush_dat = flush ? l_dat : '0;
        upd_we    = hit && ((snp_op == BUS_RDX) || (snp_op == BUS_RD && l_st == LS_MOD));
        upd_st    = (snp_op == BUS_RDX) ? LS_INV : LS_SHR;
    end
endmodule

// File: rtl/msi_req_fsm.sv
// Module: processor-side controller. It decides hit or miss, runs the
// write-back and fill transactions through request/grant/done, and
// drives the line-store writes for local writes, invalidation after
// write-back, and fills.
// Assumes: the processor holds cpu_req and its fields until cpu_ready;
// the bus shows no foreign snoop during this controller's granted cycle.
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_ready,
    input  logic               snp_valid,
    output logic [IDX_W-1:0]   look_idx,
    input  line_st_e           l_st,
    input  logic [ADDR_W-IDX_W-1:0] l_tag,
    input  logic [DATA_W-1:0]  l_dat,
    output logic               bus_req,
    input  logic               bus_gnt,
    output bus_op_e            bus_cmd,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_done,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic               wr_we,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [DATA_W-1:0]  wr_dat,
    output logic               inv_we,
    output logic               fill_we,
    output logic [IDX_W-1:0]   op_idx,
    output logic [ADDR_W-IDX_W-1:0] fill_tag,
    output logic [DATA_W-1:0]  fill_dat,
    output line_st_e           fill_st
);
    localparam int TAG_W = ADDR_W - IDX_W;

    phase_e            phase_q;
    bus_op_e           op_q;
    logic [ADDR_W-1:0] op_addr_q;

    logic [IDX_W-1:0] cpu_idx;
    logic [TAG_W-1:0] cpu_tag;
    logic tag_hit, can_do, take, need_wb, granted, finish;

    // Hit/miss decision and bus drive.
    always_comb begin
        cpu_idx   = cpu_addr[IDX_W-1:0];
        cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
        look_idx  = (phase_q == PH_IDLE) ? cpu_idx : op_addr_q[IDX_W-1:0];
        tag_hit   = (l_st != LS_INV) && (l_tag == cpu_tag);
        can_do    = cpu_we ? (tag_hit && l_st == LS_MOD) : tag_hit;
        take      = (phase_q == PH_IDLE) && cpu_req && !snp_valid;
        need_wb   = (l_st == LS_MOD) && !tag_hit;
        cpu_ready = take && can_do;
        cpu_rdata = (cpu_ready && !cpu_we) ? l_dat : '0;
        bus_req   = (phase_q != PH_IDLE);
        granted   = bus_req && bus_gnt;
        bus_cmd   = granted ? op_q : BUS_IDLE;
        bus_addr  = granted ? op_addr_q : '0;
        bus_wdata = (granted && op_q == BUS_WB) ? l_dat : '0;
        finish    = granted && bus_done;
        wr_we     = cpu_ready && cpu_we;
        wr_idx    = cpu_idx;
        wr_dat    = cpu_wdata;
        inv_we    = finish && (phase_q == PH_WB);
        fill_we   = finish && (phase_q == PH_FILL);
        op_idx    = op_addr_q[IDX_W-1:0];
        fill_tag  = op_addr_q[ADDR_W-1:IDX_W];
        fill_dat  = bus_rdata;
        fill_st   = (op_q == BUS_RDX) ? LS_MOD : LS_SHR;
    end

    // Transaction sequencing: start on a miss, return to idle when done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            op_q      <= BUS_IDLE;
            op_addr_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (take && !can_do) begin
                        if (need_wb) begin
                            phase_q   <= PH_WB;
                            op_q      <= BUS_WB;
                            op_addr_q <= {l_tag, cpu_idx};
                        end else begin
                            phase_q   <= PH_FILL;
                            op_q      <= cpu_we ? BUS_RDX : BUS_RD;
                            op_addr_q <= cpu_addr;
                        end
                    end
                end
                default: begin
                    if (finish)
                        phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    // R11: a pending transaction is held until grant and done coincide.
    p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !(bus_gnt && bus_done)) |=> bus_req);

    // R11: the processor is never released while the bus is in use.
    p_ready_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_ready);

    // R12: a snoop takes the cycle; the processor waits.
    p_snoop_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !cpu_ready);

    // R9: a fetch never goes out while a dirty foreign line still sits in the slot.
    p_no_dirty_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && op_q != BUS_WB)
            |-> !(l_st == LS_MOD && l_tag != op_addr_q[ADDR_W-1:IDX_W]));
endmodule

// File: rtl/msi_cache_ctrl.sv
// Module: top of the MSI snooping cache controller. Wires the line store,
// the snoop decoder and the processor-side controller together.
// Assumes: one word per line; index = low IDX_W address bits.
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int LINES = 1 << IDX_W;

    logic [IDX_W-1:0]  look_idx, wr_idx, op_idx, s_idx;
    line_st_e          a_st, b_st, upd_st, fill_st;
    logic [TAG_W-1:0]  a_tag, b_tag, fill_tag, s_tag;
    logic [DATA_W-1:0] a_dat, b_dat, wr_dat, fill_dat;
    logic              upd_we, wr_we, inv_we, fill_we;
    bus_op_e           cmd_e;
    logic [2*LINES-1:0] st_vec;

    assign s_idx   = snp_addr[IDX_W-1:0];
    assign s_tag   = snp_addr[ADDR_W-1:IDX_W];
    assign bus_cmd = cmd_e;

    msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(look_idx), .a_st(a_st), .a_tag(a_tag), .a_dat(a_dat),
        .b_idx(s_idx), .b_st(b_st), .b_tag(b_tag), .b_dat(b_dat),
        .snp_we(upd_we), .snp_idx(s_idx), .snp_st(upd_st),
        .cpu_we(wr_we), .cpu_idx(wr_idx), .cpu_dat(wr_dat),
        .inv_we(inv_we), .inv_idx(op_idx),
        .fill_we(fill_we), .fill_idx(op_idx), .fill_tag(fill_tag),
        .fill_dat(fill_dat), .fill_st(fill_st),
        .st_vec(st_vec)
    );

    msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_op(bus_op_e'(snp_cmd)), .snp_tag(s_tag),
        .l_st(b_st), .l_tag(b_tag), .l_dat(b_dat),
        .flush(snp_flush), .flush_dat(snp_data),
        .upd_we(upd_we), .upd_st(upd_st)
    );

    msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .snp_valid(snp_valid), .look_idx(look_idx),
        .l_st(a_st), .l_tag(a_tag), .l_dat(a_dat),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(cmd_e),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
        .bus_rdata(bus_rdata),
        .wr_we(wr_we), .wr_idx(wr_idx), .wr_dat(wr_dat),
        .inv_we(inv_we), .fill_we(fill_we), .op_idx(op_idx),
        .fill_tag(fill_tag), .fill_dat(fill_dat), .fill_st(fill_st)
    );

    // Snoop outcome tracking for the state checks one cycle later.
    logic [IDX_W-1:0] sidx_q;
    logic             chk_shr_q, chk_inv_q;
    logic             slot_busy;
    assign slot_busy = (fill_we || inv_we) && (op_idx == s_idx);

    // Record which snooped slot must have moved, and to which state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sidx_q    <= '0;
            chk_shr_q <= 1'b0;
            chk_inv_q <= 1'b0;
        end else begin
            sidx_q    <= s_idx;
            chk_shr_q <= snp_flush && (snp_cmd == 2'd1) && !slot_busy;
            chk_inv_q <= upd_we && (snp_cmd == 2'd2) && !fill_we;
        end
    end

    // R6: a flushed line after a snooped read is left Shared.
    p_snoop_rd_to_shr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_shr_q |-> (st_vec[sidx_q*2 +: 2] == 2'b01));

    // R7: a line matched by a snooped read-exclusive ends Invalid.
    p_snoop_rdx_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_inv_q |-> (st_vec[sidx_q*2 +: 2] == 2'b00));

    // R8: a snooped write-back never draws a flush.
    p_snoop_wb_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == 2'd3) |-> !snp_flush);
endmodule

// File: tb/test_msi_cache_ctrl.sv
// Bench: directed MSI scenarios plus a behavioural per-cycle model that
// predicts every output and is compared on each clock.
module test_msi_cache_ctrl;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata, cpu_rdata;
    logic          cpu_ready;
    logic          bus_req, bus_gnt, bus_done;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          snp_valid;
    logic [1:0]    snp_cmd;
    logic [AW-1:0] snp_addr;
    logic          snp_flush;
    logic [DW-1:0] snp_data;

    always #2 clk = ~clk;   // 250 MHz

    msi_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(2)) i_msi_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
        .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_flush(snp_flush), .snp_data(snp_data)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] memv(input int a);
        return DW'((a * 16'h0101) ^ 16'h5a00);
    endfunction

    // Memory and bus-slave model
    logic [DW-1:0] mem [256];
    logic [1:0]    log_cmd  [$];
    logic [AW-1:0] log_addr [$];
    logic [DW-1:0] log_data [$];

    initial begin
        int sl;
        sl = 0;
        for (int i = 0; i < 256; i++) mem[i] = memv(i);
        bus_gnt = 1'b0; bus_done = 1'b0; bus_rdata = '0;
        forever begin
            @(negedge clk);
            case (sl)
                0: if (bus_req) sl = 1;
                1: begin
                    chk("R11 no command before grant", {30'd0, bus_cmd}, 32'd0);
                    bus_gnt = 1'b1;
                    sl = 2;
                end
                2: begin
                    log_cmd.push_back(bus_cmd);
                    log_addr.push_back(bus_addr);
                    log_data.push_back(bus_wdata);
                    if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
                    bus_rdata = mem[bus_addr];
                    bus_done = 1'b1;
                    sl = 3;
                end
                default: begin
                    bus_gnt = 1'b0; bus_done = 1'b0;
                    sl = 0;
                end
            endcase
        end
    end

    // Behavioural reference model, compared every cycle
    int            m_st  [4];
    int            m_tag [4];
    logic [DW-1:0] m_dat [4];
    int            m_ph, m_op;
    logic [AW-1:0] m_oa;

    initial begin
        forever begin
            int ci, ct, li, si, stg, ph0;
            logic shit, e_flush, thit, cando, take, e_ready, e_breq, fin, bad;
            logic [1:0] e_cmd;
            @(negedge clk);
            #1;
            ci = int'(cpu_addr[1:0]); ct = int'(cpu_addr[7:2]);
            si = int'(snp_addr[1:0]); stg = int'(snp_addr[7:2]);
            li = (m_ph == 0) ? ci : int'(m_oa[1:0]);
            shit    = snp_valid && m_st[si] != 0 && m_tag[si] == stg;
            e_flush = shit && m_st[si] == 3 && (snp_cmd == 2'd1 || snp_cmd == 2'd2);
            thit    = m_st[ci] != 0 && m_tag[ci] == ct;
            cando   = cpu_we ? (thit && m_st[ci] == 3) : thit;
            take    = m_ph == 0 && cpu_req && !snp_valid;
            e_ready = take && cando;
            e_breq  = m_ph != 0;
            e_cmd   = (e_breq && bus_gnt) ? 2'(m_op) : 2'd0;
            if (rst_n) begin
                bad = 1'b0;
                n_cmp++;
                if (cpu_ready !== e_ready) begin bad = 1; $display("FAIL R2 cpu_ready: actual %0h expected %0h", cpu_ready, e_ready); end
                if (e_ready && !cpu_we && cpu_rdata !== m_dat[ci]) begin bad = 1; $display("FAIL R2 cpu_rdata: actual %0h expected %0h", cpu_rdata, m_dat[ci]); end
                if (bus_req !== e_breq) begin bad = 1; $display("FAIL R11 bus_req: actual %0h expected %0h", bus_req, e_breq); end
                if (bus_cmd !== e_cmd) begin bad = 1; $display("FAIL R11 bus_cmd: actual %0h expected %0h", bus_cmd, e_cmd); end
                if (e_cmd != 0 && bus_addr !== m_oa) begin bad = 1; $display("FAIL R9 bus_addr: actual %0h expected %0h", bus_addr, m_oa); end
                if (e_cmd == 2'd3 && bus_wdata !== m_dat[li]) begin bad = 1; $display("FAIL R9 bus_wdata: actual %0h expected %0h", bus_wdata, m_dat[li]); end
                if (snp_flush !== e_flush) begin bad = 1; $display("FAIL R6 snp_flush: actual %0h expected %0h", snp_flush, e_flush); end
                if (e_flush && snp_data !== m_dat[si]) begin bad = 1; $display("FAIL R6 snp_data: actual %0h expected %0h", snp_data, m_dat[si]); end
                if (bad) n_bad++;
            end
            @(posedge clk);
            if (!rst_n) begin
                for (int k = 0; k < 4; k++) begin m_st[k] = 0; m_tag[k] = 0; m_dat[k] = '0; end
                m_ph = 0; m_op = 0; m_oa = '0;
            end else begin
                ph0 = m_ph;
                fin = e_breq && bus_gnt && bus_done;
                if (shit) begin
                    if (snp_cmd == 2'd1 && m_st[si] == 3) m_st[si] = 1;
                    if (snp_cmd == 2'd2) m_st[si] = 0;
                end
                if (e_ready && cpu_we) m_dat[ci] = cpu_wdata;
                if (fin && ph0 == 1) begin
                    m_st[m_oa[1:0]] = 0; m_ph = 0;
                end else if (fin && ph0 == 2) begin
                    m_st[m_oa[1:0]]  = (m_op == 2) ? 3 : 1;
                    m_tag[m_oa[1:0]] = int'(m_oa[7:2]);
                    m_dat[m_oa[1:0]] = bus_rdata;
                    m_ph = 0;
                end
                if (ph0 == 0 && take && !cando) begin
                    if (m_st[ci] == 3) begin
                        m_ph = 1; m_op = 3; m_oa = {6'(m_tag[ci]), 2'(ci)};
                    end else begin
                        m_ph = 2; m_op = cpu_we ? 2 : 1; m_oa = cpu_addr;
                    end
                end
            end
        end
    end

    // Stimulus helpers; each is entered and left at a falling edge.
    task automatic do_cpu(input logic we, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] rd);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        while (!cpu_ready) begin @(negedge clk); #1; end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic do_snoop(input logic [1:0] c, input logic [AW-1:0] a,
                            output logic fl, output logic [DW-1:0] fd);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        fl = snp_flush; fd = snp_data;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rd, fd;
        logic fl;
        int n;
        rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
        snp_valid = 0; snp_cmd = '0; snp_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 cpu_ready after reset", {31'd0, cpu_ready}, 0);
        chk("R1 bus_req after reset", {31'd0, bus_req}, 0);
        chk("R1 snp_flush after reset", {31'd0, snp_flush}, 0);
        @(negedge clk);

        // R1/R4: read miss fetches and installs Shared
        do_cpu(0, 8'h10, '0, rd);
        chk("R4 read miss data", {16'd0, rd}, {16'd0, memv(8'h10)});
        chk("R1 R4 first access is bus read", {30'd0, log_cmd[$]}, 1);
        chk("R4 read address", {24'd0, log_addr[$]}, 32'h10);
        n = log_cmd.size();
        do_cpu(0, 8'h10, '0, rd);
        chk("R2 shared read local", log_cmd.size(), n);

        // R3: write to Shared upgrades
        do_cpu(1, 8'h10, 16'h1111, rd);
        chk("R3 upgrade issues read-exclusive", {30'd0, log_cmd[$]}, 2);
        chk("R3 one bus op", log_cmd.size(), n + 1);
        n = log_cmd.size();
        do_cpu(1, 8'h10, 16'h2222, rd);
        do_cpu(0, 8'h10, '0, rd);
        chk("R2 modified read data", {16'd0, rd}, 32'h2222);
        chk("R2 modified accesses local", log_cmd.size(), n);

        // R6: snooped read flushes and downgrades
        do_snoop(2'd1, 8'h10, fl, fd);
        chk("R6 flush on snooped read", {31'd0, fl}, 1);
        chk("R6 flush data", {16'd0, fd}, 32'h2222);
        do_snoop(2'd1, 8'h10, fl, fd);
        chk("R6 shared line does not flush", {31'd0, fl}, 0);
        do_cpu(1, 8'h10, 16'h3333, rd);
        chk("R6 downgraded line needs upgrade", {30'd0, log_cmd[$]}, 2);

        // R5/R7: write miss installs Modified; snooped rdx takes it
        n = log_cmd.size();
        do_cpu(1, 8'h21, 16'hBBBB, rd);
        chk("R5 write miss read-exclusive", {30'd0, log_cmd[$]}, 2);
        do_cpu(0, 8'h21, '0, rd);
        chk("R5 write merged", {16'd0, rd}, 32'hBBBB);
        chk("R5 no extra bus op", log_cmd.size(), n + 1);
        do_snoop(2'd2, 8'h21, fl, fd);
        chk("R7 modified flush on rdx", {31'd0, fl}, 1);
        chk("R7 flush data", {16'd0, fd}, 32'hBBBB);
        do_cpu(0, 8'h21, '0, rd);
        chk("R7 invalidated line refetched", {30'd0, log_cmd[$]}, 1);

        // R7: Shared line invalidated without flush
        do_cpu(0, 8'h32, '0, rd);
        do_snoop(2'd2, 8'h32, fl, fd);
        chk("R7 shared no flush", {31'd0, fl}, 0);
        n = log_cmd.size();
        do_cpu(0, 8'h32, '0, rd);
        chk("R7 shared invalidated", log_cmd.size(), n + 1);

        // R8: ignored snoops
        do_snoop(2'd3, 8'h10, fl, fd);
        chk("R8 snooped write-back no flush", {31'd0, fl}, 0);
        do_snoop(2'd1, 8'h50, fl, fd);
        chk("R8 other tag no flush", {31'd0, fl}, 0);
        n = log_cmd.size();
        do_cpu(1, 8'h10, 16'h4444, rd);
        chk("R8 line still modified", log_cmd.size(), n);

        // R9: dirty eviction
        do_cpu(1, 8'h43, 16'hDDDD, rd);
        n = log_cmd.size();
        do_cpu(0, 8'h53, '0, rd);
        chk("R9 two bus ops", log_cmd.size(), n + 2);
        chk("R9 write-back first", {30'd0, log_cmd[n]}, 3);
        chk("R9 write-back address", {24'd0, log_addr[n]}, 32'h43);
        chk("R9 write-back data", {16'd0, log_data[n]}, 32'hDDDD);
        chk("R9 then fetch", {30'd0, log_cmd[n+1]}, 1);
        chk("R9 memory updated", {16'd0, mem[8'h43]}, 32'hDDDD);
        chk("R9 new data", {16'd0, rd}, {16'd0, memv(8'h53)});

        // R10: clean eviction is silent
        n = log_cmd.size();
        do_cpu(0, 8'h62, '0, rd);
        chk("R10 single fetch", log_cmd.size(), n + 1);
        chk("R10 fetch is read", {30'd0, log_cmd[$]}, 1);

        // R12: snoop beats a same-cycle read
        snp_valid = 1; snp_cmd = 2'd1; snp_addr = 8'h10;
        cpu_req = 1; cpu_we = 0; cpu_addr = 8'h10;
        #1;
        chk("R12 ready held during snoop", {31'd0, cpu_ready}, 0);
        chk("R12 snoop flushed", {31'd0, snp_flush}, 1);
        @(negedge clk);
        snp_valid = 0;
        #1;
        chk("R12 read then completes", {31'd0, cpu_ready}, 1);
        chk("R12 read data", {16'd0, cpu_rdata}, 32'h4444);
        @(negedge clk);
        cpu_req = 0;

        // R12: snoop rdx beats a same-cycle write, write re-misses
        do_cpu(1, 8'h10, 16'h5555, rd);
        n = log_cmd.size();
        snp_valid = 1; snp_cmd = 2'd2; snp_addr = 8'h10;
        cpu_req = 1; cpu_we = 1; cpu_addr = 8'h10; cpu_wdata = 16'h6666;
        #1;
        chk("R12 write held during snoop", {31'd0, cpu_ready}, 0);
        @(negedge clk);
        snp_valid = 0;
        #1;
        while (!cpu_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
        chk("R12 write re-evaluated as miss", log_cmd.size(), n + 1);
        do_cpu(0, 8'h10, '0, rd);
        chk("R12 final data", {16'd0, rd}, 32'h6666);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule